// File: doc/BRIEF.md
# Shared-Address Expansion I/O Port

This block provides one 8-bit input port and one 8-bit output port for a processor's external bus. The two ports share a single address window inside a chip-select area. No further address decoding is done: the area chip select alone selects the port. A read cycle puts the external input pins on the upper byte of the data bus through a three-state drive. A high-byte write cycle loads the upper data byte into an output holding stage that drives the output pins.

Reads and writes reach different storage. The output stage therefore cannot be read back, and a read always returns the live input pins. An access that the bus controller routes to on-chip memory or registers is flagged by an internal-hit input, and that flag keeps the port silent. The output holding stage is modelled as a level-sensitive register that is sampled on the clock. While the write enable is active it follows the bus on every cycle, and it keeps its last value once the enable drops. Software is expected to write the output port before it relies on the pins. The reset value is a parameter.

Top module: `xio_port`

## Requirements
- R1: `dataOe` is 1 exactly when `csN` is 0, `rdN` is 0 and `intHit` is 0. It is 0 in every other input combination.
- R2: While `dataOe` is 1, `dataOut[15:8]` equals `pinsIn` and `dataOut[7:0]` is zero. While `dataOe` is 0, `dataOut` is all zeros.
- R3: On a clock edge where `csN` is 0, `hwrN` is 0 and `intHit` is 0, `portOut` takes the value `dataIn[15:8]`, visible after that edge.
- R4: While the write enable stays active over several cycles, `portOut` follows each new `dataIn[15:8]` one edge after it is presented.
- R5: On a clock edge where the write enable is inactive, `portOut` keeps its previous value.
- R6: A read issued right after a write returns `pinsIn`, never the value held in `portOut`.
- R7: While `intHit` is 1, the port neither drives the bus nor updates `portOut`, whatever the state of `csN`, `rdN` and `hwrN`.
- R8: `dataIn[7:0]` has no effect on `portOut`.
- R9: While `rstN` is 0, and after reset until the first write, `portOut` equals `PORT_INIT` (default 0x00).
- R10: `rdN` or `hwrN` at 0 with `csN` at 1 neither drives the bus nor changes `portOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the output stage |
| rstN | input | 1 | Active-low reset |
| csN | input | 1 | Active-low area chip select |
| rdN | input | 1 | Active-low read strobe |
| hwrN | input | 1 | Active-low upper-byte write strobe |
| intHit | input | 1 | Access hits on-chip space; port stays silent |
| dataIn | input | 16 | Data bus value seen by the port |
| pinsIn | input | 8 | External input pins |
| dataOut | output | 16 | Value the port drives onto the data bus |
| dataOe | output | 1 | Bus drive enable; 0 means high impedance |
| portOut | output | 8 | External output pins |

## Verification
The assertions assume that `rdN` and `hwrN` are never both low in the same cycle. A legal bus controller never issues a read and a write together. They also assume that the bus inputs are stable around each sampling edge. The stimulus changes inputs only on the falling clock edge and never combines a read strobe with a write strobe. This holds for the directed steps and for the pseudo-random phase, which picks one of a fixed set of legal strobe combinations.

// File: rtl/xio_pkg.sv
package xio_pkg;
  // Strobes passed from the control decode to the datapath
  typedef struct packed {
    logic rdEn;     // drive input pins onto the bus
    logic latchEn;  // output stage follows the bus
  } xioStrb_t;
endpackage

// File: rtl/xio_ctrl.sv
module xio_ctrl
  import xio_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     csN,
  input  logic     rdN,
  input  logic     hwrN,
  input  logic     intHit,
  output xioStrb_t strb
);

  logic areaSel;

  // An on-chip hit wins over the area select
  assign areaSel      = !csN && !intHit;
  assign strb.rdEn    = areaSel && !rdN;
  assign strb.latchEn = areaSel && !hwrN;

  // R7: an internal hit leaves both strobes idle
  a_r7_hit_quiet: assert property (@(posedge clk) disable iff (!rstN)
    intHit |-> (!strb.rdEn && !strb.latchEn));

  // R10: no strobe without the area chip select
  a_r10_needs_cs: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> (!strb.rdEn && !strb.latchEn));

endmodule

// File: rtl/xio_datapath.sv
module xio_datapath
  import xio_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PORT_W = 8,
  parameter logic [PORT_W-1:0] PORT_INIT = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  xioStrb_t          strb,
  input  logic [PORT_W-1:0] laneIn,
  input  logic [PORT_W-1:0] pinsIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic [PORT_W-1:0] portOut
);

  localparam int LANE_LO = DATA_W - PORT_W;

  logic [PORT_W-1:0] holdQ;

  // Level-sensitive stage sampled on the clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      holdQ <= PORT_INIT;
    else if (strb.latchEn)
      holdQ <= laneIn;
  end

  assign portOut = holdQ;
  assign dataOe  = strb.rdEn;
  assign dataOut = strb.rdEn ? {pinsIn, {LANE_LO{1'b0}}} : '0;

  // R5: an inactive enable keeps the held value
  a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.latchEn |=> $stable(holdQ));

  // R3: an active enable loads the upper lane
  a_r3_capture: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchEn |=> (holdQ == $past(laneIn)));

endmodule

// File: rtl/xio_port.sv
module xio_port
  import xio_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PORT_W = 8,
  parameter logic [PORT_W-1:0] PORT_INIT = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rdN,
  input  logic              hwrN,
  input  logic              intHit,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [PORT_W-1:0] pinsIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic [PORT_W-1:0] portOut
);

  localparam int LANE_LO = DATA_W - PORT_W;

  xioStrb_t strb;
  logic     unusedLowLane;

  // The lower lane is not part of this port
  assign unusedLowLane = ^dataIn[LANE_LO-1:0];

  xio_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .csN    (csN),
    .rdN    (rdN),
    .hwrN   (hwrN),
    .intHit (intHit),
    .strb   (strb)
  );

  xio_datapath #(
    .DATA_W    (DATA_W),
    .PORT_W    (PORT_W),
    .PORT_INIT (PORT_INIT)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .laneIn  (dataIn[DATA_W-1:LANE_LO]),
    .pinsIn  (pinsIn),
    .dataOut (dataOut),
    .dataOe  (dataOe),
    .portOut (portOut)
  );

  // R1: a bus drive needs chip select and read with no internal hit
  a_r1_drive_cond: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> (!csN && !rdN && !intHit));

  // R6: driven data is the live pins, not the output stage
  a_r6_reads_pins: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> (dataOut[DATA_W-1:LANE_LO] == pinsIn));

  // R2: a quiet port puts nothing on the bus
  a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !dataOe |-> (dataOut == '0));

  // R8: a write with no upper-lane change leaves the pins alone
  a_r8_lane_only: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !hwrN && !intHit && (dataIn[DATA_W-1:LANE_LO] == portOut)) |=> $stable(portOut));

endmodule

// File: tb/tb_xio_port.sv
module tb_xio_port;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1, rdN = 1'b1, hwrN = 1'b1, intHit = 1'b0;
  logic [15:0] dataIn = '0;
  logic [7:0]  pinsIn = '0;
  logic [15:0] dataOut;
  logic        dataOe;
  logic [7:0]  portOut;

  int compared = 0;
  int mismatched = 0;
  logic [7:0] refHold = 8'h00;  // behavioural model of the output stage

  always #2.5 clk = ~clk;  // 200 MHz

  xio_port dut (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .hwrN(hwrN),
    .intHit(intHit), .dataIn(dataIn), .pinsIn(pinsIn),
    .dataOut(dataOut), .dataOe(dataOe), .portOut(portOut)
  );

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Drive one cycle on the falling edge, compare, then advance the model
  task automatic step(input string req, input logic cs, input logic rd,
                      input logic hwr, input logic hit,
                      input logic [15:0] d, input logic [7:0] p);
    logic        expOe;
    logic [15:0] expOut;
    @(negedge clk);
    csN = cs; rdN = rd; hwrN = hwr; intHit = hit; dataIn = d; pinsIn = p;
    #1;
    expOe  = !cs && !rd && !hit;
    expOut = expOe ? {p, 8'h00} : 16'h0000;
    check(req, "dataOe",  {15'b0, dataOe}, {15'b0, expOe});
    check(req, "dataOut", dataOut, expOut);
    check(req, "portOut", {8'h00, portOut}, {8'h00, refHold});
    @(posedge clk);
    if (!cs && !hwr && !hit) refHold = d[15:8];
  endtask

  task automatic idle(input string req);
    step(req, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0000, 8'h00);
  endtask

  initial begin
    #(200000 * 5);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // R9: reset value
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9", "portOut in reset", {8'h00, portOut}, 16'h0000);
    rstN = 1'b1;
    idle("R9");
    idle("R5");

    // R3 then R5: single write and hold
    step("R3", 1'b0, 1'b1, 1'b0, 1'b0, 16'hA55A, 8'h00);
    idle("R5");
    idle("R5");

    // R4: enable held while data moves
    step("R4", 1'b0, 1'b1, 1'b0, 1'b0, 16'h1100, 8'h00);
    step("R4", 1'b0, 1'b1, 1'b0, 1'b0, 16'h2200, 8'h00);
    step("R4", 1'b0, 1'b1, 1'b0, 1'b0, 16'h3300, 8'h00);
    idle("R4");

    // R1 and R2: reads of several pin patterns
    step("R1", 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 8'h5A);
    step("R2", 1'b0, 1'b0, 1'b1, 1'b0, 16'hFFFF, 8'hFF);
    step("R2", 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 8'h00);
    idle("R2");

    // R6: read straight after a write returns the pins
    step("R6", 1'b0, 1'b1, 1'b0, 1'b0, 16'hC300, 8'h3C);
    step("R6", 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 8'h3C);
    idle("R6");

    // R7: internal hit silences both directions
    step("R7", 1'b0, 1'b1, 1'b0, 1'b1, 16'h7700, 8'h81);
    step("R7", 1'b0, 1'b0, 1'b1, 1'b1, 16'h0000, 8'h81);
    idle("R7");

    // R10: strobes without chip select
    step("R10", 1'b1, 1'b1, 1'b0, 1'b0, 16'h9900, 8'h42);
    step("R10", 1'b1, 1'b0, 1'b1, 1'b0, 16'h0000, 8'h42);
    idle("R10");

    // R8: lower lane varies, upper lane fixed
    step("R8", 1'b0, 1'b1, 1'b0, 1'b0, 16'h6E00, 8'h00);
    step("R8", 1'b0, 1'b1, 1'b0, 1'b0, 16'h6EFF, 8'h00);
    step("R8", 1'b0, 1'b1, 1'b0, 1'b0, 16'h6E5A, 8'h00);
    idle("R8");

    // Mixed legal traffic
    for (int i = 0; i < 60; i++) begin
      int unsigned kind = $urandom % 5;
      logic [15:0] d = 16'($urandom);
      logic [7:0]  p = 8'($urandom);
      case (kind)
        0: step("R3", 1'b0, 1'b1, 1'b0, 1'b0, d, p);
        1: step("R1", 1'b0, 1'b0, 1'b1, 1'b0, d, p);
        2: step("R7", 1'b0, 1'b1, 1'b0, 1'b1, d, p);
        3: step("R10", 1'b1, 1'b1, 1'b0, 1'b0, d, p);
        default: step("R5", 1'b1, 1'b1, 1'b1, 1'b0, d, p);
      endcase
    end
    idle("R5");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule